// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer Group

This block holds a small group of general-purpose timer channels behind one 32-bit register port. Each channel has a 64-bit counter that counts up or down, one step per tick of a 16-bit clock prescaler. A 64-bit start value is held in a load register and is copied into the counter by a reload strobe. A 64-bit alarm comparator can raise an interrupt and can also reload the counter automatically. Software cannot read the running counter directly. It first writes a snapshot trigger, which freezes a copy of the count, and then reads that copy as two 32-bit halves. The two halves therefore always come from the same count.

The register port is plain control access. Writes are a single-cycle strobe with an address and data, and read data is a combinational function of the read address. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Word addresses are split into a channel index in the upper bits and a 4-bit offset in the lower bits. The index with every bit set selects the group registers. Each channel drives two interrupt pins: a level output and a one-cycle edge output. The channel's mode bit decides which of the two is live.

Top module: `ptmr_group`

## Requirements
- R1: After reset, every register reads 0, the counters hold 0, and both interrupt outputs are low.
- R2: Writing channel offset 3 copies the live count into the snapshot. Offsets 1 and 2 return its low and high halves. The snapshot does not change until the next trigger.
- R3: The divider field is bits [31:16] of the configuration word at offset 0. Field value D gives one tick every D clocks for D in 2..65535. D=0 gives one tick every 65536 clocks, and D=1 behaves as 2.
- R4: Configuration bit 1 set makes each tick increment the count, and bit 1 clear makes it decrement. The count wraps modulo 2^64.
- R5: The load value is written at offsets 4 (low) and 5 (high). Writing offset 6 copies it into the counter and restarts the prescaler.
- R6: Configuration bit 0 runs the counter. While it is clear, the count and the prescaler phase hold.
- R7: The alarm value is written at offsets 7 (low) and 8 (high) and is armed by configuration bit 3. On a tick whose stepped count equals the alarm value, the channel's status bit sets and counting continues.
- R8: An alarm match clears the arm bit, which reads back as 0.
- R9: If configuration bit 2 is set, an alarm match loads the counter from the load register instead of the stepped value.
- R10: Group offset 1 reports raw status, bit i for channel i, whatever the enables are. Writing 1s to group offset 2 clears those bits, and 0 bits leave status unchanged. A new alarm match wins over a clear in the same cycle.
- R11: Group offset 0 holds the interrupt enables. With configuration bit 4 clear, irq_lvl[i] is high while status and enable are both set. With bit 4 set, irq_lvl[i] stays low and irq_edge[i] pulses for exactly one cycle, in the cycle the status bit sets, if the channel is enabled.
- R12: Any write to the configuration word restarts the prescaler phase. The first tick after the write comes D clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write word address: channel index and offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq_lvl | output | N_TMR | Level interrupts, one per channel |
| irq_edge | output | N_TMR | Single-cycle edge interrupts, one per channel |

## Verification
The hardest cases to reach are those that only exist at an exact prescaled tick. An alarm can match on the very tick that also reloads the counter and drops the arm bit. The divide-by-65536 setting ticks only once in more than sixty-five thousand clocks. The stimulus places the alarm a few ticks after a known load value and records the clock edge of every register write. It then predicts the exact cycle of the status change and the edge pulse, and the count after the reload. It also runs one long wait with a zero divider field. Randomised divider, direction, start value and restart points are used to test wrap-around and phase restarts.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 2 * REG_W;
  localparam int DIV_W = 16;
  localparam int OFS_W = 4;

  // channel word offsets
  localparam logic [OFS_W-1:0] OFS_CFG      = 4'd0;
  localparam logic [OFS_W-1:0] OFS_SNAP_LO  = 4'd1;
  localparam logic [OFS_W-1:0] OFS_SNAP_HI  = 4'd2;
  localparam logic [OFS_W-1:0] OFS_SNAP_TRG = 4'd3;
  localparam logic [OFS_W-1:0] OFS_LOAD_LO  = 4'd4;
  localparam logic [OFS_W-1:0] OFS_LOAD_HI  = 4'd5;
  localparam logic [OFS_W-1:0] OFS_RELOAD   = 4'd6;
  localparam logic [OFS_W-1:0] OFS_ALARM_LO = 4'd7;
  localparam logic [OFS_W-1:0] OFS_ALARM_HI = 4'd8;

  // group word offsets
  localparam logic [OFS_W-1:0] GOFS_IEN  = 4'd0;
  localparam logic [OFS_W-1:0] GOFS_STAT = 4'd1;
  localparam logic [OFS_W-1:0] GOFS_CLR  = 4'd2;

  typedef struct packed {
    logic [DIV_W-1:0]       div;
    logic [REG_W-DIV_W-6:0] rsvd;
    logic                   edge_mode;
    logic                   arm;
    logic                   autold;
    logic                   up;
    logic                   run;
  } cfg_t;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] lim;

  // terminal phase: 0 means full 2^DIV_W range, 1 is clamped to 2
  always_comb begin
    if (div_i == '0)      lim = '1;
    else if (div_i == 1)  lim = DIV_W'(1);
    else                  lim = div_i - DIV_W'(1);
  end

  assign tick_o = run_i && (pc_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= '0;
    else if (restart_i) pc_q <= '0;
    else if (run_i)     pc_q <= tick_o ? '0 : pc_q + DIV_W'(1);
  end

  // R3: phase never passes the terminal count
  a_r3_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= lim);
  // R6: a paused prescaler keeps its phase
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(pc_q));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [REG_W-1:0] wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [REG_W-1:0] rd_data,
  output logic             fire_o,
  output logic             edge_mode_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q, snap_q, load_q, alarm_q, cnt_step;
  logic             tick, cfg_wr, reload_wr, snap_wr;

  assign cfg_wr    = wr_en && (wr_ofs == OFS_CFG);
  assign reload_wr = wr_en && (wr_ofs == OFS_RELOAD);
  assign snap_wr   = wr_en && (wr_ofs == OFS_SNAP_TRG);

  ptmr_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (cfg_q.run),
    .restart_i (cfg_wr || reload_wr),
    .div_i     (cfg_q.div),
    .tick_o    (tick)
  );

  assign cnt_step    = cfg_q.up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  assign fire_o      = tick && cfg_q.arm && (cnt_step == alarm_q);
  assign edge_mode_o = cfg_q.edge_mode;

  // configuration word; a match drops the arm bit unless software rewrites it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'(wr_data);
    else if (fire_o) cfg_q.arm <= 1'b0;
  end

  // load and alarm halves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      alarm_q <= '0;
    end else if (wr_en) begin
      case (wr_ofs)
        OFS_LOAD_LO:  load_q[REG_W-1:0]      <= wr_data;
        OFS_LOAD_HI:  load_q[CNT_W-1:REG_W]  <= wr_data;
        OFS_ALARM_LO: alarm_q[REG_W-1:0]     <= wr_data;
        OFS_ALARM_HI: alarm_q[CNT_W-1:REG_W] <= wr_data;
        default: ;
      endcase
    end
  end

  // counter: software reload beats a tick in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (reload_wr) cnt_q <= load_q;
    else if (tick)      cnt_q <= (fire_o && cfg_q.autold) ? load_q : cnt_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_wr) snap_q <= cnt_q;
  end

  always_comb begin
    case (rd_ofs)
      OFS_CFG:      rd_data = cfg_q;
      OFS_SNAP_LO:  rd_data = snap_q[REG_W-1:0];
      OFS_SNAP_HI:  rd_data = snap_q[CNT_W-1:REG_W];
      OFS_LOAD_LO:  rd_data = load_q[REG_W-1:0];
      OFS_LOAD_HI:  rd_data = load_q[CNT_W-1:REG_W];
      OFS_ALARM_LO: rd_data = alarm_q[REG_W-1:0];
      OFS_ALARM_HI: rd_data = alarm_q[CNT_W-1:REG_W];
      default:      rd_data = '0;
    endcase
  end

  // R2: snapshot frozen between triggers
  a_r2_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(snap_q));
  // R6: paused counter holds
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.run && !reload_wr) |=> $stable(cnt_q));
  // R8: a match disarms the comparator
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !cfg_wr) |=> !cfg_q.arm);
  // R9: auto-reload lands on the load value
  a_r9_autoreload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && cfg_q.autold && !reload_wr) |=> (cnt_q == $past(load_q)));
endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic         ien_wr_i,
  input  logic [N-1:0] ien_data_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ien_o,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] irq_lvl_o,
  output logic [N-1:0] irq_edge_o
);
  logic [N-1:0] ien_q, stat_q, edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
      edge_q <= '0;
    end else begin
      if (ien_wr_i) ien_q <= ien_data_i;
      stat_q <= (stat_q & ~clr_i) | fire_i;
      edge_q <= fire_i & ien_q & edge_mode_i;
    end
  end

  assign ien_o      = ien_q;
  assign stat_o     = stat_q;
  assign irq_lvl_o  = stat_q & ien_q & ~edge_mode_i;
  assign irq_edge_o = edge_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10: status is sticky until a clear bit hits it
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    // R7: a match always sets status
    a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[i] |=> stat_q[i]);
    // R11: edge output is a single-cycle pulse
    a_r11_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_edge_o[i] |=> !irq_edge_o[i]);
  end
endmodule

// File: rtl/ptmr_group.sv
module ptmr_group
  import ptmr_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [N_TMR-1:0]  irq_lvl,
  output logic [N_TMR-1:0]  irq_edge
);
  localparam int               IDX_W   = ADDR_W - OFS_W;
  localparam logic [IDX_W-1:0] GRP_IDX = '1;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [OFS_W-1:0] wr_ofs, rd_ofs;
  logic             grp_wr;
  logic [N_TMR-1:0] fire, edge_mode, ien, stat, clr_mask;
  logic [REG_W-1:0] ch_rd [N_TMR];

  assign wr_idx = wr_addr[ADDR_W-1:OFS_W];
  assign wr_ofs = wr_addr[OFS_W-1:0];
  assign rd_idx = rd_addr[ADDR_W-1:OFS_W];
  assign rd_ofs = rd_addr[OFS_W-1:0];
  assign grp_wr = wr_en && (wr_idx == GRP_IDX);

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    ptmr_channel u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en && (wr_idx == IDX_W'(i))),
      .wr_ofs      (wr_ofs),
      .wr_data     (wr_data),
      .rd_ofs      (rd_ofs),
      .rd_data     (ch_rd[i]),
      .fire_o      (fire[i]),
      .edge_mode_o (edge_mode[i])
    );
  end

  assign clr_mask = (grp_wr && wr_ofs == GOFS_CLR) ? wr_data[N_TMR-1:0] : '0;

  ptmr_irq #(.N(N_TMR)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .edge_mode_i (edge_mode),
    .ien_wr_i    (grp_wr && wr_ofs == GOFS_IEN),
    .ien_data_i  (wr_data[N_TMR-1:0]),
    .clr_i       (clr_mask),
    .ien_o       (ien),
    .stat_o      (stat),
    .irq_lvl_o   (irq_lvl),
    .irq_edge_o  (irq_edge)
  );

  always_comb begin
    rd_data = '0;
    if (rd_idx == GRP_IDX) begin
      case (rd_ofs)
        GOFS_IEN:  rd_data = REG_W'(ien);
        GOFS_STAT: rd_data = REG_W'(stat);
        default:   rd_data = '0;
      endcase
    end else begin
      for (int i = 0; i < N_TMR; i++)
        if (rd_idx == IDX_W'(i)) rd_data = ch_rd[i];
    end
  end

  // R11: no interrupt output can be active for a disabled channel
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_lvl | irq_edge) & ~$past(ien) & ~ien) == '0);
endmodule

// File: tb/ptmr_group_tb_top.sv
module ptmr_group_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  irq_lvl, irq_edge;

  always #10 clk = ~clk;

  ptmr_group dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_lvl(irq_lvl), .irq_edge(irq_edge)
  );

  int cyc = 0;
  int n_chk = 0, n_err = 0, last_e = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(int t, int ofs);
    return 8'((t << 4) | ofs);
  endfunction

  function automatic logic [31:0] cfgw(int div, bit edg, bit arm, bit ald, bit up, bit run);
    return {16'(div), 11'd0, edg, arm, ald, up, run};
  endfunction

  function automatic int eff_div(int d);
    if (d == 0) return 65536;
    if (d == 1) return 2;
    return d;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; last_e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic snap(int t, output logic [63:0] v, output int s);
    logic [31:0] lo, hi;
    wr(ra(t, 3), 0); s = last_e;
    rd(ra(t, 1), lo); rd(ra(t, 2), hi);
    v = {hi, lo};
  endtask

  task automatic load(int t, logic [63:0] v);
    wr(ra(t, 4), v[31:0]); wr(ra(t, 5), v[63:32]); wr(ra(t, 6), 0);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v, v2, L, ex;
    int s, e, e2, p, k, dv, t, dfield;
    bit up, rst2;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(ra(0, 0), r);  chk("R1 cfg0", 64'(r), 0);
    rd(ra(1, 7), r);  chk("R1 alarm1", 64'(r), 0);
    rd(8'hF0, r);     chk("R1 ien", 64'(r), 0);
    rd(8'hF1, r);     chk("R1 stat", 64'(r), 0);
    chk("R1 irq", {60'd0, irq_lvl, irq_edge}, 0);
    snap(0, v, s);    chk("R1 count0", v, 0);

    // R3 R4 R5 R6 R12 randomised counting
    for (int it = 0; it < 20; it++) begin
      t = int'($urandom_range(1, 0));
      dfield = int'($urandom_range(9, 1));
      dv = eff_div(dfield);
      up = 1'($urandom_range(1, 0));
      L = {$urandom, $urandom};
      if (it % 4 == 0) L = up ? 64'hFFFF_FFFF_FFFF_FFFD : 64'd2;
      wr(ra(t, 0), cfgw(dfield, 0, 0, 0, up, 0));
      load(t, L);
      wr(ra(t, 0), cfgw(dfield, 0, 0, 0, up, 1)); e = last_e;
      repeat ($urandom_range(40, 3)) @(negedge clk);
      rst2 = 1'($urandom_range(1, 0));
      k = 0;
      if (rst2) begin
        wr(ra(t, 0), cfgw(dfield, 0, 0, 0, up, 1)); e2 = last_e;
        k = (e2 - e) / dv; e = e2;
        repeat ($urandom_range(30, 2)) @(negedge clk);
      end
      snap(t, v, s);
      ex = up ? L + 64'(k + (s - 1 - e) / dv) : L - 64'(k + (s - 1 - e) / dv);
      chk($sformatf("R3 R4 R12 count it%0d", it), v, ex);
      wr(ra(t, 0), cfgw(dfield, 0, 0, 0, up, 0)); p = last_e;
      repeat ($urandom_range(20, 4)) @(negedge clk);
      snap(t, v, s);
      ex = up ? L + 64'(k + (p - e) / dv) : L - 64'(k + (p - e) / dv);
      chk($sformatf("R6 paused it%0d", it), v, ex);
    end

    // R2 snapshot stays frozen while counting
    wr(ra(1, 0), cfgw(2, 0, 0, 0, 1, 1));
    snap(1, v, s);
    repeat (20) @(negedge clk);
    rd(ra(1, 1), r); v2[31:0] = r; rd(ra(1, 2), r); v2[63:32] = r;
    chk("R2 frozen", v2, v);
    snap(1, v2, s);
    chk("R2 retrigger advanced", 64'(v2 > v), 1);
    wr(ra(1, 0), cfgw(2, 0, 0, 0, 1, 0));

    // R3 divider field 0 -> 65536 clocks per tick
    wr(ra(0, 0), cfgw(0, 0, 0, 0, 1, 0));
    load(0, 64'd50);
    wr(ra(0, 0), cfgw(0, 0, 0, 0, 1, 1)); e = last_e;
    repeat (65540) @(negedge clk);
    snap(0, v, s);
    chk("R3 div0", v, 64'd50 + 64'((s - 1 - e) / 65536));
    wr(ra(0, 0), cfgw(0, 0, 0, 0, 1, 0));

    // R7 R8 R11 level alarm on channel 0
    load(0, 64'd100);
    wr(ra(0, 7), 105); wr(ra(0, 8), 0);
    wr(8'hF0, 1);
    wr(ra(0, 0), cfgw(2, 0, 1, 0, 1, 1)); e = last_e;
    wait_to(e + 9);
    rd(8'hF1, r); chk("R7 before match", 64'(r[0]), 0);
    @(negedge clk);
    chk("R7 cycle of match", 64'(cyc), 64'(e + 10));
    rd(8'hF1, r); chk("R7 status set", 64'(r[0]), 1);
    chk("R11 level high", 64'(irq_lvl[0]), 1);
    chk("R11 no edge in level mode", 64'(irq_edge[0]), 0);
    rd(ra(0, 0), r); chk("R8 arm cleared", 64'(r[3]), 0);
    repeat (7) @(negedge clk);
    snap(0, v, s);
    chk("R7 keeps counting", v, 64'd100 + 64'((s - 1 - e) / 2));
    chk("R11 level holds", 64'(irq_lvl[0]), 1);

    // R10 clear semantics
    wr(8'hF2, 2);
    rd(8'hF1, r); chk("R10 other bit untouched", 64'(r[0]), 1);
    wr(8'hF2, 1);
    rd(8'hF1, r); chk("R10 cleared", 64'(r[0]), 0);
    chk("R11 level drops", 64'(irq_lvl[0]), 0);
    wr(ra(0, 0), cfgw(2, 0, 0, 0, 1, 0));

    // R9 R11 auto-reload with edge output on channel 1
    wr(ra(1, 0), cfgw(3, 1, 0, 1, 1, 0));
    load(1, 64'd200);
    wr(ra(1, 7), 203); wr(ra(1, 8), 0);
    wr(8'hF0, 2);
    wr(ra(1, 0), cfgw(3, 1, 1, 1, 1, 1)); e = last_e;
    k = 0; p = 0;
    for (int c = 0; c < 24; c++) begin
      if (irq_edge[1]) begin k++; p = cyc; end
      if (irq_lvl[1]) chk("R11 level silent in edge mode", 1, 0);
      @(negedge clk);
    end
    chk("R11 one edge pulse", 64'(k), 1);
    chk("R11 edge cycle", 64'(p), 64'(e + 9));
    snap(1, v, s);
    chk("R9 auto-reloaded count", v, 64'd200 + 64'((s - 1 - e) / 3 - 3));
    rd(8'hF1, r); chk("R10 status ch1", 64'(r[1]), 1);
    wr(ra(1, 0), cfgw(3, 1, 0, 1, 1, 0));

    // R10 R11 raw status with enable off, then enabled
    wr(ra(0, 0), cfgw(2, 0, 0, 0, 1, 0));
    load(0, 64'd0);
    wr(ra(0, 7), 3); wr(ra(0, 8), 0);
    wr(ra(0, 0), cfgw(2, 0, 1, 0, 1, 1));
    repeat (12) @(negedge clk);
    rd(8'hF1, r); chk("R10 raw status", 64'(r[0]), 1);
    chk("R11 masked", 64'(irq_lvl[0]), 0);
    wr(8'hF0, 3);
    chk("R11 unmasked", 64'(irq_lvl[0]), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule